// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control core of a multichannel successive-approximation converter. Software reaches it through a small register bus. It programs an enable, a channel, a single-or-burst choice, a once-or-continuous choice, an interrupt enable and a sample-settle delay, then sets a start bit. The sequencer drives the analog side through a sampling strobe and a conversion strobe. It captures the converter's result word on the last conversion cycle.

Results land in four result registers. In single mode every result goes to slot 0. In burst mode one run fills slots 0 to 3 in turn. A status register reports:
- end-of-conversion,
- busy,
- a sticky overflow flag,
- the index of the most recently written slot.

A level interrupt follows end-of-conversion when enabled. Any read of a result register clears end-of-conversion and drops the interrupt.

Top module: `adc_seq`

Register map:
- Control register at address 0.
- Status register at address 1.
- Result slot k at address 4+k, with the result zero-extended.

## Requirements
- R1: After reset every register and status bit reads 0, and `cnv_sample`, `cnv_convert` and `irq` are low. The control register (address 0) holds these fields:
  - [0] enable
  - [1] interrupt enable
  - [2] burst (1 = four conversions)
  - [3] continuous
  - [4] start
  - [5] delay-before-every-conversion
  - [10:8] channel
  - [15:12] delay D

  The status register (address 1) holds [0] end-of-conversion, [1] busy, [2] overflow and [5:4] last-written slot.
- R2: In single-once mode, end-of-conversion is first visible 11+max(D,1) clock cycles after the clock edge that writes start. The result is in slot 0, the slot field reads 0, busy reads 0 and the start bit has cleared itself.
- R3: Every conversion holds `cnv_convert` high for exactly 10 cycles and is preceded by at least one cycle of `cnv_sample`. The two strobes are never high together.
- R4: The delay bit chooses when the programmed delay applies:
  - Delay bit 0: only the first sampling phase after start lasts max(D,1) cycles, and later phases last 1 cycle. A burst then takes 1+(max(D,1)+10)+3*11 cycles to end-of-conversion.
  - Delay bit 1: every sampling phase lasts max(D,1) cycles, so a burst takes 1+4*(max(D,1)+10) cycles.
- R5: In burst mode, four successive results fill slots 0,1,2,3 in that order. End-of-conversion and the interrupt assert only after the fourth, and the slot field then reads 3.
- R6: `irq` is high exactly when end-of-conversion is set and interrupt enable is 1. A read of any result register clears end-of-conversion and drops `irq`. With interrupt enable 0, `irq` stays low.
- R7: A conversion that completes onto a slot holding unread data overwrites that slot and sets overflow.
- R8: Overflow stays set until a write to status with bit 2 = 1; a write with bit 2 = 0 leaves it set.
- R9: In continuous mode, conversions repeat without further writes while start stays 1. Clearing start lets the conversion in progress complete, with busy held high until then. No further sampling follows.
- R10: With enable 0 the sequencer returns to idle on the next cycle, busy and both strobes go low, and a set start bit is ignored.
- R11: `cnv_chan` presents the programmed channel field, and the channel also appears in the upper bits of the captured result from the bench's converter model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (result reads have side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| cnv_chan | output | 3 | Channel select toward the converter |
| cnv_sample | output | 1 | High while the sample-and-hold settles |
| cnv_convert | output | 1 | High during the 10 conversion cycles |
| cnv_result | input | 10 | Converter result, captured on the last conversion cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: four slots, 10-bit results, 3-bit channel, 4-bit delay and 10 conversion cycles. With a 4-bit delay, the whole delay range is in reach. The bench covers the zero value that is forced to one, a mid value and the maximum of 15, and checks exact end-of-conversion latencies for single runs and for bursts under both delay modes. A four-slot burst lets the bench watch the slot pointer and interrupt timing across a complete buffer fill. A continuous run without reads drives the overwrite and sticky-overflow paths.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DLY_W    = 4,
    parameter int CONV_CYC = 10,
    parameter int NBUF     = 4,
    localparam int PTR_W   = $clog2(NBUF),
    localparam int MAXC    = (CONV_CYC > (1 << DLY_W)) ? CONV_CYC : (1 << DLY_W),
    localparam int CNT_W   = $clog2(MAXC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    input  logic             burst_i,
    input  logic             cont_i,
    input  logic             dly_every_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             busy_o,
    output logic             sample_o,
    output logic             convert_o,
    output logic             done_o,
    output logic             last_o,
    output logic [PTR_W-1:0] slot_o,
    output logic             clr_start_o
);
    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [PTR_W-1:0] slot;
    } fsm_t;

    fsm_t q, d;
    logic [CNT_W-1:0] dly_eff;
    logic [CNT_W-1:0] next_dly;

    always_comb begin
        d        = q;
        done_o   = 1'b0;
        dly_eff  = (dly_i == '0) ? CNT_W'(1) : CNT_W'(dly_i);
        next_dly = dly_every_i ? dly_eff : CNT_W'(1);
        last_o   = !burst_i || (q.slot == PTR_W'(NBUF - 1));
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_SAMPLE;
                    d.cnt  = dly_eff;
                    d.slot = '0;
                end
            end
            ST_SAMPLE: begin
                if (q.cnt <= CNT_W'(1)) begin
                    d.st  = ST_CONV;
                    d.cnt = CNT_W'(CONV_CYC);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CONV: begin
                if (q.cnt <= CNT_W'(1)) begin
                    done_o = 1'b1;
                    if (!last_o && start_i) begin
                        d.st   = ST_SAMPLE;
                        d.cnt  = next_dly;
                        d.slot = q.slot + 1'b1;
                    end else if (last_o && cont_i && start_i) begin
                        d.st   = ST_SAMPLE;
                        d.cnt  = next_dly;
                        d.slot = '0;
                    end else begin
                        d.st  = ST_IDLE;
                        d.cnt = '0;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d = '0;
        endcase
        if (!en_i) begin
            d      = '0;
            done_o = 1'b0;
        end
        clr_start_o = done_o && last_o && !cont_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign sample_o  = (q.st == ST_SAMPLE);
    assign convert_o = (q.st == ST_CONV);
    assign slot_o    = q.slot;

    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && convert_o));
    a_r3_sample_before_convert: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convert_o) |-> $past(sample_o));
    a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !busy_o);
    a_r9_conversion_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && convert_o && !done_o) |=> convert_o);
endmodule

// File: rtl/adc_seq_buf.sv
module adc_seq_buf #(
    parameter int RES_W  = 10,
    parameter int NBUF   = 4,
    localparam int PTR_W = $clog2(NBUF)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        done_i,
    input  logic                        last_i,
    input  logic [PTR_W-1:0]            slot_i,
    input  logic [RES_W-1:0]            result_i,
    input  logic                        rd_stb_i,
    input  logic [PTR_W-1:0]            rd_idx_i,
    input  logic                        ovf_clr_i,
    output logic [NBUF-1:0][RES_W-1:0]  data_o,
    output logic                        eoc_o,
    output logic                        ovf_o,
    output logic [PTR_W-1:0]            ptr_o
);
    typedef struct packed {
        logic [NBUF-1:0][RES_W-1:0] data;
        logic [NBUF-1:0]            valid;
        logic                       eoc;
        logic                       ovf;
        logic [PTR_W-1:0]           ptr;
    } buf_t;

    buf_t q, d;
    logic slot_busy;

    always_comb begin
        d         = q;
        slot_busy = q.valid[slot_i] && !(rd_stb_i && (rd_idx_i == slot_i));
        if (rd_stb_i) begin
            d.eoc             = 1'b0;
            d.valid[rd_idx_i] = 1'b0;
        end
        if (ovf_clr_i) d.ovf = 1'b0;
        if (done_i) begin
            d.data[slot_i]  = result_i;
            d.valid[slot_i] = 1'b1;
            d.ptr           = slot_i;
            if (slot_busy) d.ovf = 1'b1;
            if (last_i)    d.eoc = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o = q.data;
    assign eoc_o  = q.eoc;
    assign ovf_o  = q.ovf;
    assign ptr_o  = q.ptr;

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);
    a_r6_read_clears_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !done_i) |=> !eoc_o);
    a_r5_eoc_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && last_i) |=> eoc_o);
    a_r7_overwrite_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && slot_busy) |=> ovf_o);
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
    parameter int DW       = 16,
    parameter int RES_W    = 10,
    parameter int CH_W     = 3,
    parameter int DLY_W    = 4,
    parameter int CONV_CYC = 10,
    parameter int NBUF     = 4,
    localparam int PTR_W   = $clog2(NBUF),
    localparam int ADDR_W  = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [CH_W-1:0]   cnv_chan,
    output logic              cnv_sample,
    output logic              cnv_convert,
    input  logic [RES_W-1:0]  cnv_result,
    output logic              irq
);
    localparam int CH_LSB  = 8;
    localparam int DLY_LSB = 12;

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             burst;
        logic             cont;
        logic             start;
        logic             dly_every;
        logic [CH_W-1:0]  chan;
        logic [DLY_W-1:0] dly;
    } ctrl_t;

    ctrl_t ctrl_q, ctrl_d;

    logic                       busy, done, last, clr_start;
    logic [PTR_W-1:0]           slot, ptr;
    logic [NBUF-1:0][RES_W-1:0] buf_data;
    logic                       eoc, ovf;
    logic                       sel_ctrl, sel_stat, sel_res, rd_stb, ovf_clr;

    assign sel_ctrl = (bus_addr == ADDR_W'(0));
    assign sel_stat = (bus_addr == ADDR_W'(1));
    assign sel_res  = bus_addr[ADDR_W-1];
    assign rd_stb   = bus_rd && sel_res;
    assign ovf_clr  = bus_wr && sel_stat && bus_wdata[2];

    always_comb begin
        ctrl_d = ctrl_q;
        if (clr_start) ctrl_d.start = 1'b0;
        if (bus_wr && sel_ctrl) begin
            ctrl_d.en        = bus_wdata[0];
            ctrl_d.ie        = bus_wdata[1];
            ctrl_d.burst     = bus_wdata[2];
            ctrl_d.cont      = bus_wdata[3];
            ctrl_d.start     = bus_wdata[4];
            ctrl_d.dly_every = bus_wdata[5];
            ctrl_d.chan      = bus_wdata[CH_LSB +: CH_W];
            ctrl_d.dly       = bus_wdata[DLY_LSB +: DLY_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    adc_seq_fsm #(.DLY_W(DLY_W), .CONV_CYC(CONV_CYC), .NBUF(NBUF)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctrl_q.en),
        .start_i     (ctrl_q.start),
        .burst_i     (ctrl_q.burst),
        .cont_i      (ctrl_q.cont),
        .dly_every_i (ctrl_q.dly_every),
        .dly_i       (ctrl_q.dly),
        .busy_o      (busy),
        .sample_o    (cnv_sample),
        .convert_o   (cnv_convert),
        .done_o      (done),
        .last_o      (last),
        .slot_o      (slot),
        .clr_start_o (clr_start)
    );

    adc_seq_buf #(.RES_W(RES_W), .NBUF(NBUF)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done),
        .last_i    (last),
        .slot_i    (slot),
        .result_i  (cnv_result),
        .rd_stb_i  (rd_stb),
        .rd_idx_i  (bus_addr[PTR_W-1:0]),
        .ovf_clr_i (ovf_clr),
        .data_o    (buf_data),
        .eoc_o     (eoc),
        .ovf_o     (ovf),
        .ptr_o     (ptr)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_res) begin
            bus_rdata = DW'(buf_data[bus_addr[PTR_W-1:0]]);
        end else if (sel_ctrl) begin
            bus_rdata[0]                 = ctrl_q.en;
            bus_rdata[1]                 = ctrl_q.ie;
            bus_rdata[2]                 = ctrl_q.burst;
            bus_rdata[3]                 = ctrl_q.cont;
            bus_rdata[4]                 = ctrl_q.start;
            bus_rdata[5]                 = ctrl_q.dly_every;
            bus_rdata[CH_LSB +: CH_W]    = ctrl_q.chan;
            bus_rdata[DLY_LSB +: DLY_W]  = ctrl_q.dly;
        end else if (sel_stat) begin
            bus_rdata[0]         = eoc;
            bus_rdata[1]         = busy;
            bus_rdata[2]         = ovf;
            bus_rdata[4 +: PTR_W] = ptr;
        end
    end

    assign cnv_chan = ctrl_q.chan;
    assign irq      = eoc && ctrl_q.ie;

    a_r6_result_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done) |=> !irq);
    a_r2_once_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last && !ctrl_q.cont && !bus_wr) |=> !ctrl_q.start);
endmodule

// File: tb/tb_adc_seq.sv
`timescale 1ns/100ps
module tb_adc_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  cnv_chan;
    logic        cnv_sample, cnv_convert, irq;
    logic [9:0]  cnv_result;

    int tests = 0, fails = 0;
    int stub_n = 0;
    logic prev_s = 1'b0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    adc_seq dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnv_chan(cnv_chan), .cnv_sample(cnv_sample), .cnv_convert(cnv_convert),
        .cnv_result(cnv_result), .irq(irq)
    );

    // converter model: a new sample index per sampling phase, tagged with the channel
    always @(negedge clk) begin
        if (cnv_sample && !prev_s) stub_n = stub_n + 1;
        prev_s = cnv_sample;
    end
    assign cnv_result = {cnv_chan, 7'(stub_n)};

    function automatic logic [15:0] expect_res(int idx, logic [2:0] ch);
        return {6'b0, ch, 7'(idx)};
    endfunction

    function automatic logic [15:0] mk(bit en, bit ie, bit bu, bit co, bit st,
                                       bit dm, int ch, int dl);
        return {4'(dl), 1'b0, 3'(ch), 2'b0, dm, st, co, bu, ie, en};
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic flush();
        logic [15:0] v;
        wr(3'd0, 16'h0);
        for (int k = 0; k < 4; k++) rd(3'(4 + k), v);
        wr(3'd1, 16'h0004);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); chk("R1 ctrl reset", v, 0);
        rd(3'd1, v); chk("R1 status reset", v, 0);
        chk("R1 strobes/irq reset", {cnv_sample, cnv_convert, irq}, 0);
    endtask

    task automatic t_single(int dl);
        logic [15:0] v;
        int n = 0, conv = 0, c0, deff;
        deff = (dl == 0) ? 1 : dl;
        flush();
        c0 = stub_n;
        wr(3'd0, mk(1, 1, 0, 0, 1, 0, 5, dl));
        chk("R11 channel out", cnv_chan, 5);
        while (!irq && n < 200) begin
            @(negedge clk); n++;
            if (cnv_convert) conv++;
        end
        chk("R2 single latency", n, 11 + deff);
        chk("R3 convert length", conv, 10);
        rd(3'd1, v);
        chk("R2 status eoc/busy/ptr", v, 16'h0001);
        rd(3'd0, v);
        chk("R2 start self-clear", v[4], 0);
        rd(3'd4, v);
        chk("R11 result slot0", v, expect_res(c0 + 1, 3'd5));
        chk("R6 irq drops on read", irq, 0);
        rd(3'd1, v);
        chk("R6 eoc cleared", v[0], 0);
    endtask

    task automatic t_burst(bit dm, int dl);
        logic [15:0] v;
        int n = 0, early = 0, c0, deff, exp;
        deff = (dl == 0) ? 1 : dl;
        flush();
        c0 = stub_n;
        wr(3'd0, mk(1, 1, 1, 0, 1, dm, 2, dl));
        while (!irq && n < 300) begin
            @(negedge clk); n++;
        end
        exp = dm ? 1 + 4 * (deff + 10) : 1 + (deff + 10) + 3 * 11;
        chk(dm ? "R4 burst latency every" : "R4 burst latency first", n, exp);
        chk("R5 no early irq", early, 0);
        rd(3'd1, v);
        chk("R5 status ptr3 eoc", v, 16'h0031);
        for (int k = 0; k < 4; k++) begin
            rd(3'(4 + k), v);
            chk("R5 burst slot value", v, expect_res(c0 + 1 + k, 3'd2));
            if (k == 0) chk("R6 irq after first read", irq, 0);
        end
    endtask

    task automatic t_ovf();
        logic [15:0] v;
        int falls = 0, n = 0;
        logic pc = 1'b0;
        flush();
        wr(3'd0, mk(1, 0, 0, 1, 1, 0, 6, 1));
        while (falls < 2 && n < 200) begin
            @(negedge clk); n++;
            if (pc && !cnv_convert) falls++;
            pc = cnv_convert;
        end
        rd(3'd1, v);
        chk("R7 overflow set", v[2], 1);
        chk("R9 continuous repeated", falls, 2);
        chk("R6 eoc without irq", {v[0], irq}, 2);
        wr(3'd0, mk(1, 0, 0, 1, 0, 0, 6, 1));
        n = 0;
        while (dut.cnv_sample | dut.cnv_convert) begin
            @(negedge clk); n++;
            if (n > 40) break;
        end
        rd(3'd4, v);
        chk("R7 newest overwrites", v, expect_res(stub_n, 3'd6));
        wr(3'd1, 16'h0000);
        rd(3'd1, v);
        chk("R8 write 0 keeps ovf", v[2], 1);
        wr(3'd1, 16'h0004);
        rd(3'd1, v);
        chk("R8 write 1 clears ovf", v[2], 0);
    endtask

    task automatic t_stop();
        logic [15:0] v;
        int n = 0, extra = 0;
        flush();
        wr(3'd0, mk(1, 0, 0, 1, 1, 0, 1, 2));
        while (!cnv_convert && n < 50) begin @(negedge clk); n++; end
        wr(3'd0, mk(1, 0, 0, 1, 0, 0, 1, 2));
        rd(3'd1, v);
        chk("R9 busy held after stop", v[1], 1);
        n = 0;
        do begin rd(3'd1, v); n++; end while (v[1] && n < 30);
        chk("R9 conversion completed", v[0], 1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (cnv_sample) extra++;
        end
        chk("R9 no sampling after stop", extra, 0);
        rd(3'd4, v);
        chk("R9 final result", v, expect_res(stub_n, 3'd1));
    endtask

    task automatic t_disable();
        logic [15:0] v;
        int act = 0;
        flush();
        wr(3'd0, mk(1, 0, 1, 1, 1, 0, 0, 5));
        repeat (8) @(negedge clk);
        wr(3'd0, mk(0, 0, 1, 1, 1, 0, 0, 5));
        @(negedge clk);
        chk("R10 strobes low", {cnv_sample, cnv_convert}, 0);
        for (int k = 0; k < 30; k++) begin
            rd(3'd1, v);
            if (v[1] || cnv_sample || cnv_convert) act++;
        end
        chk("R10 start ignored while disabled", act, 0);
        flush();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single(0);
        t_single(3);
        t_single(15);
        t_burst(0, 3);
        t_burst(1, 3);
        t_ovf();
        t_stop();
        t_disable();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule